// File: doc/BRIEF.md
# Host Configuration and Readback Port

This block is a small memory-mapped register file through which an 8-bit host processor streams a configuration bitstream into a device, one byte per write. After the device is configured, the host can also pull configuration memory back out through the same registers. The host bus has a chip select, a read/write line, a one-cycle strobe, a 3-bit register address, a byte data bus and an acknowledge. A level interrupt request can tell the host that the port will take another byte or that the bitstream loader has reported an error.

On the device side, each accepted download byte is held on `dl_byte` with `dl_valid` until the loader raises `dl_ready`. The loader reports errors as a one-cycle strobe with a 2-bit code. Readback runs as a stream of one-cycle fetch requests that carry a 14-bit address. The configuration-memory model answers each request with `rb_valid` and a data byte. The port stays usable after `cfg_done` only if the host set the user-mode enable before the first download byte.

Register map (`hb_addr`):
- 0 = control: bit0 error interrupt enable, bit1 ready interrupt enable, bit2 user-mode enable, bit3 readback idle (1 = idle).
- 1 = status (read only): bit0 ready, bits2:1 error code, bit3 readback data ready, bit4 overrun, bit5 `init_done`, bit6 `cfg_done`, bit7 readback busy.
- 2 = download data (write).
- 3 = readback address bits 7:0.
- 4 = readback address bits 13:8 (held in bits 5:0).
- 5 = readback data (read).

Other addresses read 0.

Top module: `cfg_host_port`

## Requirements
- R1: An access is a cycle with `hb_cs`=1 and `hb_strb`=1 while the port is usable. `hb_ack` is 1 for exactly the one clock after each access and is 0 otherwise. Read data is on `hb_rdata` while `hb_ack` is 1.
- R2: After synchronous reset, control reads 0x08, both readback address registers read 0 and readback data reads 0. Status reads 0x01, plus bit5 and bit6 mirroring their inputs. Address registers read back what was written, with bits 7:6 of address 4 reading 0.
- R3: A write to address 2 while status bit0 is 1 puts the byte on `dl_byte` and sets `dl_valid`. The byte and `dl_valid` are held until a clock edge with `dl_ready`=1. Status bit0 is 0 while `dl_valid` is 1 and returns to 1 after the handshake.
- R4: A write to address 2 while status bit0 is 0 is ignored: `dl_byte` is unchanged and no extra byte is delivered. It sets the sticky overrun bit, status bit4, which only reset clears.
- R5: A `bs_err_stb` pulse with a nonzero `bs_err_code` loads that code into status bits 2:1 and latches an error-pending flag. A zero code does nothing.
- R6: `hb_irq` is a registered level, one clock behind its sources. It is 1 when (control bit0 and error pending) or (control bit1 and status bit0).
- R7: Reading status clears error pending, so `hb_irq` falls from error alone. The error code in bits 2:1 is kept.
- R8: Writing control with bit3=0 while readback is idle starts readback. The engine loads the 14-bit start address {addr4[5:0], addr3} and raises `rb_req` for one clock with `rb_addr` at that address. Status bit7 reads 1 while readback runs.
- R9: An `rb_valid` answer to an outstanding request is latched into the readback data register and sets status bit3. Reading address 5 while bit3 is 1 clears bit3, advances the address by one (wrapping at 14 bits) and issues the next request.
- R10: Error strobes are ignored while readback runs: status bits 2:1 do not change.
- R11: The user-mode enable (control bit2) can be changed only until the first download write. When `cfg_done`=1 and user mode is off, accesses get no acknowledge and have no effect.
- R12: Writing control with bit3=1 stops readback. This clears status bits 3 and 7, and control bit3 then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_cs | input | 1 | Host chip select |
| hb_strb | input | 1 | Host access strobe, one cycle per access |
| hb_wr | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 3 | Register address |
| hb_wdata | input | 8 | Host write data |
| hb_rdata | output | 8 | Host read data, valid with acknowledge |
| hb_ack | output | 1 | One-cycle access acknowledge |
| hb_irq | output | 1 | Level interrupt request |
| init_done | input | 1 | Device initialisation complete |
| cfg_done | input | 1 | Device configuration complete |
| dl_byte | output | 8 | Download byte to loader |
| dl_valid | output | 1 | Download byte valid |
| dl_ready | input | 1 | Loader takes the byte |
| bs_err_stb | input | 1 | Bitstream error report strobe |
| bs_err_code | input | 2 | Bitstream error code |
| rb_req | output | 1 | One-cycle readback fetch request |
| rb_addr | output | 14 | Readback fetch address |
| rb_valid | input | 1 | Readback byte returned |
| rb_data | input | 8 | Readback byte |

## Verification
The hardest state to reach is a readback in progress that meets an error report while the user-mode lock is in force. Reaching it takes an ordered run: set user mode before any download byte, drive a download through the overrun case, raise an error and clear its interrupt, assert `cfg_done`, then start readback from an address next to the 14-bit wrap. A responding memory stub logs every requested address, which checks the wrap from 0x3FFF to 0. An error strobe is injected between readback bytes to show the error field stays frozen. A second reset then leaves user mode off, so that accesses after `cfg_done` can be shown to go unacknowledged and to leave the control register unchanged.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;
  localparam int HA_W = 3;

  localparam logic [HA_W-1:0] RA_CTRL   = 3'd0;
  localparam logic [HA_W-1:0] RA_STATUS = 3'd1;
  localparam logic [HA_W-1:0] RA_DLDATA = 3'd2;
  localparam logic [HA_W-1:0] RA_RBLO   = 3'd3;
  localparam logic [HA_W-1:0] RA_RBHI   = 3'd4;
  localparam logic [HA_W-1:0] RA_RBDATA = 3'd5;

  // control bit positions
  localparam int CB_ERR_IE = 0;
  localparam int CB_RDY_IE = 1;
  localparam int CB_USER   = 2;
  localparam int CB_RBIDLE = 3;

  typedef struct packed {
    logic err_ie;
    logic rdy_ie;
    logic user_en;
  } ctrl_t;

  typedef struct packed {
    logic       rb_busy;
    logic       cfg_done;
    logic       init_done;
    logic       overrun;
    logic       drdy;
    logic [1:0] err;
    logic       rdy;
  } status_t;
endpackage

// File: rtl/cfg_bus_front.sv
module cfg_bus_front #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          strb,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          active,
  input  logic [DW-1:0] rd_word,
  output logic          acc_rd,
  output logic          acc_wr,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] rdata,
  output logic          ack
);
  logic hit;

  assign hit       = cs & strb & active;
  assign acc_wr    = hit & wr;
  assign acc_rd    = hit & ~wr;
  assign acc_addr  = addr;
  assign acc_wdata = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= hit;
      if (acc_rd) rdata <= rd_word;
    end
  end
endmodule

// File: rtl/cfg_dl_path.sv
module cfg_dl_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          dl_ready,
  output logic [DW-1:0] dl_byte,
  output logic          dl_valid,
  output logic          rdy,
  output logic          overrun,
  output logic          started
);
  assign rdy = ~dl_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_byte  <= '0;
      dl_valid <= 1'b0;
      overrun  <= 1'b0;
      started  <= 1'b0;
    end else begin
      if (dl_valid && dl_ready) dl_valid <= 1'b0;
      if (wr_en) begin
        started <= 1'b1;
        if (!dl_valid) begin
          dl_byte  <= wdata;
          dl_valid <= 1'b1;
        end else begin
          overrun <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_err_irq.sv
module cfg_err_irq #(
  parameter int EW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          err_stb,
  input  logic [EW-1:0] err_code,
  input  logic          rb_busy,
  input  logic          stat_rd,
  input  logic          err_ie,
  input  logic          rdy_ie,
  input  logic          rdy,
  output logic [EW-1:0] err_field,
  output logic          err_pend,
  output logic          irq
);
  logic err_load;

  assign err_load = err_stb & (|err_code) & ~rb_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_field <= '0;
      err_pend  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (err_load) begin
        err_field <= err_code;
        err_pend  <= 1'b1;
      end else if (stat_rd) begin
        err_pend <= 1'b0;
      end
      irq <= (err_ie & err_pend) | (rdy_ie & rdy);
    end
  end
endmodule

// File: rtl/cfg_rb_engine.sv
module cfg_rb_engine #(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          data_rd,
  input  logic [AW-1:0] start_addr,
  input  logic          rb_valid,
  input  logic [DW-1:0] rb_data,
  output logic          rb_req,
  output logic [AW-1:0] rb_addr,
  output logic          busy,
  output logic          drdy,
  output logic [DW-1:0] rdata
);
  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_req  <= 1'b0;
      rb_addr <= '0;
      busy    <= 1'b0;
      drdy    <= 1'b0;
      rdata   <= '0;
      waiting <= 1'b0;
    end else begin
      rb_req <= 1'b0;
      if (stop) begin
        busy    <= 1'b0;
        drdy    <= 1'b0;
        waiting <= 1'b0;
      end else if (start) begin
        busy    <= 1'b1;
        rb_addr <= start_addr;
        rb_req  <= 1'b1;
        waiting <= 1'b1;
        drdy    <= 1'b0;
      end else if (busy) begin
        if (waiting && rb_valid) begin
          rdata   <= rb_data;
          drdy    <= 1'b1;
          waiting <= 1'b0;
        end else if (data_rd && drdy) begin
          drdy    <= 1'b0;
          rb_addr <= rb_addr + 1'b1;
          rb_req  <= 1'b1;
          waiting <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_host_port.sv
module cfg_host_port
  import cfg_host_pkg::*;
#(
  parameter int DW    = 8,
  parameter int RBA_W = 14,
  parameter int EW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hb_cs,
  input  logic             hb_strb,
  input  logic             hb_wr,
  input  logic [HA_W-1:0]  hb_addr,
  input  logic [DW-1:0]    hb_wdata,
  output logic [DW-1:0]    hb_rdata,
  output logic             hb_ack,
  output logic             hb_irq,
  input  logic             init_done,
  input  logic             cfg_done,
  output logic [DW-1:0]    dl_byte,
  output logic             dl_valid,
  input  logic             dl_ready,
  input  logic             bs_err_stb,
  input  logic [EW-1:0]    bs_err_code,
  output logic             rb_req,
  output logic [RBA_W-1:0] rb_addr,
  input  logic             rb_valid,
  input  logic [DW-1:0]    rb_data
);
  localparam int HI_W = RBA_W - DW;

  ctrl_t           ctrl;
  status_t         stat;
  logic [DW-1:0]   rba_lo;
  logic [HI_W-1:0] rba_hi;
  logic            active;
  logic            acc_rd, acc_wr;
  logic [HA_W-1:0] acc_addr;
  logic [DW-1:0]   acc_wdata;
  logic [DW-1:0]   rd_word;
  logic            dl_rdy, overrun, started;
  logic [EW-1:0]   err_field;
  logic            err_pend;
  logic            rb_busy, rb_drdy;
  logic [DW-1:0]   rb_word;
  logic            wr_ctrl, rb_start, rb_stop;

  assign active   = ~cfg_done | ctrl.user_en;
  assign wr_ctrl  = acc_wr && (acc_addr == RA_CTRL);
  assign rb_start = wr_ctrl && !acc_wdata[CB_RBIDLE] && !rb_busy;
  assign rb_stop  = wr_ctrl &&  acc_wdata[CB_RBIDLE] &&  rb_busy;

  cfg_bus_front #(.DW(DW), .AW(HA_W)) u_front (
    .clk(clk), .rst(rst), .cs(hb_cs), .strb(hb_strb), .wr(hb_wr),
    .addr(hb_addr), .wdata(hb_wdata), .active(active), .rd_word(rd_word),
    .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rdata(hb_rdata), .ack(hb_ack)
  );

  cfg_dl_path #(.DW(DW)) u_dl (
    .clk(clk), .rst(rst),
    .wr_en(acc_wr && (acc_addr == RA_DLDATA)), .wdata(acc_wdata),
    .dl_ready(dl_ready), .dl_byte(dl_byte), .dl_valid(dl_valid),
    .rdy(dl_rdy), .overrun(overrun), .started(started)
  );

  cfg_err_irq #(.EW(EW)) u_err (
    .clk(clk), .rst(rst), .err_stb(bs_err_stb), .err_code(bs_err_code),
    .rb_busy(rb_busy), .stat_rd(acc_rd && (acc_addr == RA_STATUS)),
    .err_ie(ctrl.err_ie), .rdy_ie(ctrl.rdy_ie), .rdy(dl_rdy),
    .err_field(err_field), .err_pend(err_pend), .irq(hb_irq)
  );

  cfg_rb_engine #(.AW(RBA_W), .DW(DW)) u_rb (
    .clk(clk), .rst(rst), .start(rb_start), .stop(rb_stop),
    .data_rd(acc_rd && (acc_addr == RA_RBDATA)),
    .start_addr({rba_hi, rba_lo}), .rb_valid(rb_valid), .rb_data(rb_data),
    .rb_req(rb_req), .rb_addr(rb_addr), .busy(rb_busy), .drdy(rb_drdy),
    .rdata(rb_word)
  );

  // control and readback address registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl   <= '0;
      rba_lo <= '0;
      rba_hi <= '0;
    end else if (acc_wr) begin
      case (acc_addr)
        RA_CTRL: begin
          ctrl.err_ie <= acc_wdata[CB_ERR_IE];
          ctrl.rdy_ie <= acc_wdata[CB_RDY_IE];
          if (!started) ctrl.user_en <= acc_wdata[CB_USER];
        end
        RA_RBLO: rba_lo <= acc_wdata;
        RA_RBHI: rba_hi <= acc_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    stat.rb_busy   = rb_busy;
    stat.cfg_done  = cfg_done;
    stat.init_done = init_done;
    stat.overrun   = overrun;
    stat.drdy      = rb_drdy;
    stat.err       = err_field;
    stat.rdy       = dl_rdy;
  end

  always_comb begin
    rd_word = '0;
    case (acc_addr)
      RA_CTRL: begin
        rd_word[CB_ERR_IE] = ctrl.err_ie;
        rd_word[CB_RDY_IE] = ctrl.rdy_ie;
        rd_word[CB_USER]   = ctrl.user_en;
        rd_word[CB_RBIDLE] = ~rb_busy;
      end
      RA_STATUS: rd_word = stat;
      RA_RBLO:   rd_word = rba_lo;
      RA_RBHI:   rd_word[HI_W-1:0] = rba_hi;
      RA_RBDATA: rd_word = rb_word;
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/cfg_host_port_chk.sv
module cfg_host_port_chk #(
  parameter int DW = 8,
  parameter int EW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          hb_cs,
  input logic          hb_strb,
  input logic          active,
  input logic          hb_ack,
  input logic          dl_valid,
  input logic          dl_ready,
  input logic [DW-1:0] dl_byte,
  input logic          overrun,
  input logic          rb_busy,
  input logic          rb_drdy,
  input logic          rb_req,
  input logic [EW-1:0] err_field
);
  assert_ack_follows_R1: assert property (@(posedge clk) disable iff (rst)
    (hb_cs && hb_strb && active) |=> hb_ack);

  assert_no_stray_ack_R1: assert property (@(posedge clk) disable iff (rst)
    !(hb_cs && hb_strb && active) |=> !hb_ack);

  assert_dl_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (dl_valid && !dl_ready) |=> (dl_valid && $stable(dl_byte)));

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_err_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (rb_busy && $past(rb_busy)) |-> $stable(err_field));

  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rb_req |=> !rb_req);

  assert_drdy_in_busy_R12: assert property (@(posedge clk) disable iff (rst)
    rb_drdy |-> rb_busy);
endmodule

bind cfg_host_port cfg_host_port_chk #(.DW(DW), .EW(EW)) u_chk (
  .clk(clk), .rst(rst), .hb_cs(hb_cs), .hb_strb(hb_strb), .active(active),
  .hb_ack(hb_ack), .dl_valid(dl_valid), .dl_ready(dl_ready),
  .dl_byte(dl_byte), .overrun(overrun), .rb_busy(rb_busy),
  .rb_drdy(rb_drdy), .rb_req(rb_req), .err_field(err_field)
);

// File: tb/cfg_host_port_tb.sv
module cfg_host_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hb_cs = 1'b0, hb_strb = 1'b0, hb_wr = 1'b0;
  logic [2:0]  hb_addr = '0;
  logic [7:0]  hb_wdata = '0;
  logic [7:0]  hb_rdata;
  logic        hb_ack, hb_irq;
  logic        init_done = 1'b0, cfg_done = 1'b0;
  logic [7:0]  dl_byte;
  logic        dl_valid;
  logic        dl_ready = 1'b0;
  logic        bs_err_stb = 1'b0;
  logic [1:0]  bs_err_code = '0;
  logic        rb_req;
  logic [13:0] rb_addr;
  logic        rb_valid = 1'b0;
  logic [7:0]  rb_data = '0;

  int nchk = 0, nfail = 0, ndeliv = 0, nreq = 0;
  logic [13:0] req_log [8];
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_host_port u_dut (.*);

  // memory model stub: answers each request one cycle later
  function automatic logic [7:0] mem_val(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5C;
  endfunction

  always @(posedge clk) begin
    rb_valid <= 1'b0;
    if (rb_req) begin
      rb_valid <= 1'b1;
      rb_data  <= mem_val(rb_addr);
      if (nreq < 8) req_log[nreq] <= rb_addr;
      nreq <= nreq + 1;
    end
    if (dl_valid && dl_ready) ndeliv <= ndeliv + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [2:0] a, input logic [7:0] d,
                     output logic [7:0] q, output logic k);
    @(negedge clk);
    hb_cs = 1'b1; hb_strb = 1'b1; hb_wr = w; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_cs = 1'b0; hb_strb = 1'b0; hb_wr = 1'b0;
    k = hb_ack; q = hb_rdata;
  endtask

  task automatic pulse_ready();
    @(negedge clk); dl_ready = 1'b1;
    @(negedge clk); dl_ready = 1'b0;
  endtask

  task automatic pulse_err(input logic [1:0] c);
    @(negedge clk); bs_err_stb = 1'b1; bs_err_code = c;
    @(negedge clk); bs_err_stb = 1'b0; bs_err_code = '0;
  endtask

  // {wr, addr[2:0], wdata[7:0], expected read[7:0]}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'h00, 8'h08},
    {1'b0, 3'd1, 8'h00, 8'h21},
    {1'b0, 3'd3, 8'h00, 8'h00},
    {1'b0, 3'd4, 8'h00, 8'h00},
    {1'b0, 3'd5, 8'h00, 8'h00},
    {1'b1, 3'd3, 8'hFE, 8'h00},
    {1'b1, 3'd4, 8'hFF, 8'h00},
    {1'b0, 3'd3, 8'h00, 8'hFE},
    {1'b0, 3'd4, 8'h00, 8'h3F},
    {1'b0, 3'd7, 8'h00, 8'h00}
  };

  initial begin
    logic [7:0] q;
    logic k;
    logic [13:0] ea;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    init_done = 1'b1;

    // R2: reset values and address register table
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][19], VEC[i][18:16], VEC[i][15:8], q, k);
      if (!VEC[i][19]) chk("R2 table read", {24'h0, q}, {24'h0, VEC[i][7:0]});
    end

    // R1: acknowledge one clock after access, then low
    bus(1'b1, 3'd0, 8'h0C, q, k);
    chk("R1 ack after access", {31'h0, k}, 32'h1);
    @(negedge clk);
    chk("R1 ack drops", {31'h0, hb_ack}, 32'h0);
    bus(1'b0, 3'd0, 8'h00, q, k);
    chk("R11 user enable set", {24'h0, q}, 32'h0C);

    // R6: ready interrupt
    bus(1'b1, 3'd0, 8'h0E, q, k);
    @(negedge clk);
    chk("R6 irq from ready", {31'h0, hb_irq}, 32'h1);
    bus(1'b1, 3'd0, 8'h0C, q, k);
    @(negedge clk);
    chk("R6 irq masked", {31'h0, hb_irq}, 32'h0);

    // R3 / R4: download and overrun
    bus(1'b1, 3'd2, 8'h5A, q, k);
    chk("R3 dl_valid", {31'h0, dl_valid}, 32'h1);
    chk("R3 dl_byte", {24'h0, dl_byte}, 32'h5A);
    bus(1'b0, 3'd1, 8'h00, q, k);
    chk("R3 ready low while held", {31'h0, q[0]}, 32'h0);
    bus(1'b1, 3'd2, 8'h77, q, k);
    chk("R4 byte unchanged", {24'h0, dl_byte}, 32'h5A);
    bus(1'b0, 3'd1, 8'h00, q, k);
    chk("R4 overrun flag", {31'h0, q[4]}, 32'h1);
    pulse_ready();
    @(negedge clk);
    chk("R3 dl_valid after handshake", {31'h0, dl_valid}, 32'h0);
    chk("R4 one byte delivered", ndeliv, 32'd1);
    bus(1'b0, 3'd1, 8'h00, q, k);
    chk("R3 ready back", {31'h0, q[0]}, 32'h1);
    chk("R4 overrun sticky", {31'h0, q[4]}, 32'h1);

    // R11: user enable locked after first download byte
    bus(1'b1, 3'd0, 8'h08, q, k);
    bus(1'b0, 3'd0, 8'h00, q, k);
    chk("R11 user enable locked", {24'h0, q}, 32'h0C);

    // R5 / R6 / R7: error report and interrupt
    bus(1'b1, 3'd0, 8'h09, q, k);
    pulse_err(2'b00);
    @(negedge clk); @(negedge clk);
    chk("R5 zero code ignored", {31'h0, hb_irq}, 32'h0);
    pulse_err(2'b10);
    @(negedge clk); @(negedge clk);
    chk("R6 irq from error", {31'h0, hb_irq}, 32'h1);
    bus(1'b0, 3'd1, 8'h00, q, k);
    chk("R5 error code", {30'h0, q[2:1]}, 32'h2);
    @(negedge clk); @(negedge clk);
    chk("R7 irq cleared by status read", {31'h0, hb_irq}, 32'h0);
    bus(1'b0, 3'd1, 8'h00, q, k);
    chk("R7 error code kept", {30'h0, q[2:1]}, 32'h2);

    // cfg_done mirror, port still usable in user mode
    cfg_done = 1'b1;
    bus(1'b0, 3'd1, 8'h00, q, k);
    chk("R11 ack in user mode", {31'h0, k}, 32'h1);
    chk("R2 cfg_done mirror", {31'h0, q[6]}, 32'h1);

    // R8 / R9 / R10: readback from 0x3FFE across the wrap
    bus(1'b1, 3'd0, 8'h04, q, k);
    bus(1'b0, 3'd1, 8'h00, q, k);
    chk("R8 busy", {31'h0, q[7]}, 32'h1);
    ea = 14'h3FFE;
    for (int b = 0; b < 3; b++) begin
      q = 8'h00;
      for (int t = 0; t < 20 && !q[3]; t++) bus(1'b0, 3'd1, 8'h00, q, k);
      chk("R9 data ready", {31'h0, q[3]}, 32'h1);
      bus(1'b0, 3'd5, 8'h00, q, k);
      chk("R9 readback byte", {24'h0, q}, {24'h0, mem_val(ea)});
      chk("R8 request address", {18'h0, req_log[b]}, {18'h0, ea});
      bus(1'b0, 3'd1, 8'h00, q, k);
      chk("R9 data ready cleared", {31'h0, q[3]}, 32'h0);
      if (b == 1) begin
        pulse_err(2'b01);
        bus(1'b0, 3'd1, 8'h00, q, k);
        chk("R10 error frozen", {30'h0, q[2:1]}, 32'h2);
      end
      ea = ea + 14'd1;
    end

    // R12: stop readback
    bus(1'b1, 3'd0, 8'h0C, q, k);
    bus(1'b0, 3'd1, 8'h00, q, k);
    chk("R12 busy cleared", {31'h0, q[7]}, 32'h0);
    chk("R12 data ready cleared", {31'h0, q[3]}, 32'h0);
    bus(1'b0, 3'd0, 8'h00, q, k);
    chk("R12 idle bit", {24'h0, q}, 32'h0C);

    // R11: no user mode, port closed after configuration
    @(negedge clk); rst = 1'b1; cfg_done = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    bus(1'b1, 3'd2, 8'h33, q, k);
    pulse_ready();
    cfg_done = 1'b1;
    bus(1'b1, 3'd2, 8'h44, q, k);
    chk("R11 no ack when closed", {31'h0, k}, 32'h0);
    chk("R11 write ignored", {31'h0, dl_valid}, 32'h0);
    bus(1'b1, 3'd0, 8'h02, q, k);
    cfg_done = 1'b0;
    bus(1'b0, 3'd0, 8'h00, q, k);
    chk("R11 control unchanged", {24'h0, q}, 32'h08);
    chk("R11 irq off", {31'h0, hb_irq}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule